// File: doc/BRIEF.md
# I2C Slave Configuration Register Port

This block lets an I2C bus master read and write a bank of byte-wide configuration registers. A fast system clock samples SCL and SDA. The block drives SDA only through an open-drain enable: when `sda_oe` is high, the pad pulls the line low. A strap input chooses one of two 7-bit device addresses. Every transfer starts with a register pointer byte. Data bytes then move to or from the register at the pointer, and the pointer steps forward after each byte.

A write transfer has three parts: the device address with the write bit, the pointer byte, then any number of data bytes until STOP. A read transfer has two parts: the device address with the read bit, then bytes from the current pointer. A read is normally reached by a repeated START after the pointer has been set. The master acknowledges each byte it wants to continue and sends NACK on the last one. The register contents are presented in parallel on `cfg_flat` for the rest of the chip.

There is no streaming data path at the block's edge, so the block has no valid/ready handshake. All pins are plain levels. Back-pressure on the bus is out of scope because the block never stretches the clock.

Top module: `i2c_reg_slave`

## Requirements
- R1: While `rst_n` is low and after it returns high, `sda_oe` is 0. Register i holds its default value (i*37+5) mod 256, and its byte sits at `cfg_flat[8*i+7 : 8*i]`.
- R2: The first byte after a START is received MSB first. Its upper seven bits are compared with 0011000 when `addr_sel` is 0 and with 0011001 when `addr_sel` is 1. Its lowest bit is 1 for a read and 0 for a write.
  - On a match, the slave pulls SDA low during the ninth clock.
  - On a mismatch it never drives SDA. It ignores all bus traffic until the next START, so no register changes.
- R3: In a write, the byte after the device address is loaded into the register pointer and acknowledged. The pointer keeps its value after STOP.
- R4: `sda_oe` changes only while SCL is low. The data bits the slave sends are stable for the whole SCL high time.
- R5: Each data byte in a write is acknowledged and stored at the pointer, and the pointer then increments. A write may start at any pointer value and continues for any number of bytes up to STOP. The pointer wraps from 255 to 0.
- R6: A pointer value at or above the register count (16 by default) still gets an acknowledge. A write there changes no register, and a read there returns 0x00.
- R7: In a read, the slave sends the register at the current pointer MSB first and increments the pointer after each byte. It continues after a master ACK (SDA low in the ninth clock). After a master NACK it releases SDA and stays silent until the next START.
- R8: A STOP releases SDA and ends the transfer. A START at any point abandons the transfer in progress, and no partial byte is written.
- R9: Asserting `rst_n` low in the middle of a transfer returns every register to its default and releases SDA.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_sel | input | 1 | Chooses the device address (bit 0 of the 7-bit address) |
| scl_i | input | 1 | I2C clock line as seen at the pad |
| sda_i | input | 1 | I2C data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls SDA low (open-drain enable) |
| cfg_flat | output | NREG*8 | All registers, register i in bits 8*i+7 : 8*i |

## Verification
A wrong internal state is visible on the bus within one byte time:
- A bad bit count or byte-phase state moves the acknowledge out of the ninth clock, and the master sees it at the next sample point.
- A pointer that fails to step, or steps twice, shows up as the wrong register on `cfg_flat` right after the write byte completes, or as a wrong byte on the following read.
- A slave that wrongly stays active after an address mismatch or a NACK shows up as a register changed by traffic meant for another device.

The sweep covers each start pointer in and just beyond the bank, so the out-of-range rules and the pointer boundary are both exercised.

// File: rtl/i2c_regif_pkg.sv
package i2c_regif_pkg;

  typedef enum logic [3:0] {
    PH_IDLE,
    PH_DEV,
    PH_DEVACK,
    PH_PTR,
    PH_PTRACK,
    PH_WR,
    PH_WRACK,
    PH_RD,
    PH_RDACK
  } phase_t;

  function automatic logic [7:0] cfg_default(input int unsigned idx);
    return 8'((idx * 37 + 5) % 256);
  endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic level_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], line_i};
      last  <= chain[STAGES-1];
    end
  end

  assign level_o = chain[STAGES-1];
  assign rise_o  = chain[STAGES-1] & ~last;
  assign fall_o  = ~chain[STAGES-1] & last;
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank
  import i2c_regif_pkg::*;
#(
  parameter int NREG   = 16,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata,
  output logic [NREG*8-1:0] cfg_flat
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [7:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n)
        mem[g] <= cfg_default(g);
      else if (we && waddr == ADDR_W'(g))
        mem[g] <= wdata;
    end
    assign cfg_flat[g*8 +: 8] = mem[g];
  end

  always_comb begin
    if (32'(raddr) < NREG)
      rdata = mem[raddr[IDX_W-1:0]];
    else
      rdata = 8'h00;
  end
endmodule

// File: rtl/i2c_slave_fsm.sv
module i2c_slave_fsm
  import i2c_regif_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              sda,
  input  logic              sda_rise,
  input  logic              sda_fall,
  input  logic [6:0]        dev_addr,
  input  logic [7:0]        rd_data,
  output logic [ADDR_W-1:0] ptr_o,
  output logic              we_o,
  output logic [7:0]        wdata_o,
  output logic              start_o,
  output logic              sda_oe_o
);
  phase_t            ph;
  logic [2:0]        cnt;
  logic [7:0]        rx;
  logic [7:0]        tx;
  logic              got;
  logic              rw;
  logic              mack;
  logic              oe;
  logic [ADDR_W-1:0] ptr;
  logic              start_evt;
  logic              stop_evt;

  assign start_evt = scl & sda_fall;
  assign stop_evt  = scl & sda_rise;

  assign we_o     = (ph == PH_WR) && scl_fall && got && !start_evt && !stop_evt;
  assign wdata_o  = rx;
  assign ptr_o    = ptr;
  assign start_o  = start_evt;
  assign sda_oe_o = oe;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      cnt  <= '0;
      rx   <= '0;
      tx   <= '0;
      got  <= 1'b0;
      rw   <= 1'b0;
      mack <= 1'b0;
      oe   <= 1'b0;
      ptr  <= '0;
    end else if (start_evt) begin
      ph  <= PH_DEV;
      cnt <= '0;
      got <= 1'b0;
      oe  <= 1'b0;
    end else if (stop_evt) begin
      ph  <= PH_IDLE;
      got <= 1'b0;
      oe  <= 1'b0;
    end else begin
      case (ph)
        PH_DEV, PH_PTR, PH_WR: begin
          if (scl_rise) begin
            rx  <= {rx[6:0], sda};
            cnt <= 3'(cnt + 3'd1);
            if (cnt == 3'd7) got <= 1'b1;
          end else if (scl_fall && got) begin
            got <= 1'b0;
            if (ph == PH_DEV) begin
              if (rx[7:1] == dev_addr) begin
                rw <= rx[0];
                oe <= 1'b1;
                ph <= PH_DEVACK;
              end else begin
                ph <= PH_IDLE;
              end
            end else if (ph == PH_PTR) begin
              ptr <= rx[ADDR_W-1:0];
              oe  <= 1'b1;
              ph  <= PH_PTRACK;
            end else begin
              ptr <= ptr + 1'b1;
              oe  <= 1'b1;
              ph  <= PH_WRACK;
            end
          end
        end
        PH_DEVACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              tx <= rd_data;
              oe <= ~rd_data[7];
              ph <= PH_RD;
            end else begin
              oe <= 1'b0;
              ph <= PH_PTR;
            end
          end
        end
        PH_PTRACK, PH_WRACK: begin
          if (scl_fall) begin
            oe  <= 1'b0;
            cnt <= '0;
            ph  <= PH_WR;
          end
        end
        PH_RD: begin
          if (scl_fall) begin
            if (cnt == 3'd7) begin
              oe  <= 1'b0;
              ptr <= ptr + 1'b1;
              ph  <= PH_RDACK;
            end else begin
              tx  <= {tx[6:0], 1'b0};
              oe  <= ~tx[6];
              cnt <= 3'(cnt + 3'd1);
            end
          end
        end
        PH_RDACK: begin
          if (scl_rise) begin
            mack <= ~sda;
          end else if (scl_fall) begin
            if (mack) begin
              tx  <= rd_data;
              oe  <= ~rd_data[7];
              cnt <= '0;
              ph  <= PH_RD;
            end else begin
              ph <= PH_IDLE;
            end
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_reg_slave.sv
module i2c_reg_slave #(
  parameter int         NREG        = 16,
  parameter int         ADDR_W      = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_BASE    = 7'b0011000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  output logic [NREG*8-1:0] cfg_flat
);
  logic              scl_lvl, scl_rise, scl_fall;
  logic              sda_lvl, sda_rise, sda_fall;
  logic [6:0]        dev_addr;
  logic [ADDR_W-1:0] ptr;
  logic              bank_we;
  logic [7:0]        bank_wdata;
  logic [7:0]        bank_rdata;
  logic              start_evt;

  assign dev_addr = DEV_BASE | {6'b0, addr_sel};

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .line_i(scl_i),
    .level_o(scl_lvl), .rise_o(scl_rise), .fall_o(scl_fall)
  );

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .line_i(sda_i),
    .level_o(sda_lvl), .rise_o(sda_rise), .fall_o(sda_fall)
  );

  i2c_slave_fsm #(.ADDR_W(ADDR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .scl(scl_lvl), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .sda(sda_lvl), .sda_rise(sda_rise), .sda_fall(sda_fall),
    .dev_addr(dev_addr), .rd_data(bank_rdata),
    .ptr_o(ptr), .we_o(bank_we), .wdata_o(bank_wdata),
    .start_o(start_evt), .sda_oe_o(sda_oe)
  );

  i2c_cfg_bank #(.NREG(NREG), .ADDR_W(ADDR_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .we(bank_we), .waddr(ptr), .wdata(bank_wdata),
    .raddr(ptr), .rdata(bank_rdata), .cfg_flat(cfg_flat)
  );
endmodule

// File: rtl/i2c_reg_slave_chk.sv
module i2c_reg_slave_chk #(
  parameter int NREG   = 16,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              sda_oe,
  input logic [NREG*8-1:0] cfg_flat,
  input logic              we,
  input logic [ADDR_W-1:0] ptr,
  input logic [7:0]        wdata,
  input logic              start_evt
);
  localparam int IDX_W = (NREG > 1) ? $clog2(NREG) : 1;

  logic [7:0]        regv [NREG];
  logic              pend;
  logic [ADDR_W-1:0] pa;
  logic [7:0]        pd;

  for (genvar g = 0; g < NREG; g++) begin : g_v
    assign regv[g] = cfg_flat[g*8 +: 8];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      pa   <= '0;
      pd   <= '0;
    end else begin
      pend <= we && (32'(ptr) < NREG);
      pa   <= ptr;
      pd   <= wdata;
    end
  end

  // R5: a write strobe in range lands in the addressed register
  a_r5_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    pend |-> regv[pa[IDX_W-1:0]] == pd);

  // R5: the pointer steps by one after each stored byte
  a_r5_ptr_steps: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> ptr == $past(ptr) + 1'b1);

  // R4: the open-drain enable moves only while SCL is low
  a_r4_oe_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R8: a START releases SDA
  a_r8_start_release: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> !sda_oe);

  // R1: SDA is released when reset ends
  a_r1_reset_release: assert property (@(posedge clk)
    $rose(rst_n) |-> !sda_oe);
endmodule

bind i2c_reg_slave i2c_reg_slave_chk #(.NREG(NREG), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
  .cfg_flat(cfg_flat), .we(bank_we), .ptr(ptr), .wdata(bank_wdata),
  .start_evt(start_evt)
);

// File: tb/sim_i2c_reg_slave.sv
`timescale 1ns/1ps
module sim_i2c_reg_slave;
  localparam int NREG = 16;
  localparam int Q    = 10;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              addr_sel = 1'b0;
  logic              scl_m = 1'b1;
  logic              sda_m = 1'b1;
  logic              sda_line;
  logic              sda_oe;
  logic [NREG*8-1:0] cfg_flat;

  int total = 0;
  int bad   = 0;
  logic [7:0] model [NREG];

  always #2 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_reg_slave #(.NREG(NREG)) u0 (
    .clk(clk), .rst_n(rst_n), .addr_sel(addr_sel),
    .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe), .cfg_flat(cfg_flat)
  );

  function automatic logic [7:0] dflt(input int i);
    return 8'((i * 37 + 5) % 256);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0;
    end
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    ack = ~sda_line;
    wq(Q);
    scl_m = 1'b0;
  endtask

  task automatic read_byte(input logic give_ack, output logic [7:0] b, output logic steady);
    steady = 1'b1;
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      scl_m = 1'b1; wq(1);
      b[i] = sda_line;
      wq(2*Q - 1);
      if (sda_line !== b[i]) steady = 1'b0;
      scl_m = 1'b0;
    end
    sda_m = give_ack ? 1'b0 : 1'b1; wq(Q);
    scl_m = 1'b1; wq(2*Q);
    scl_m = 1'b0;
    wq(Q/2);
    sda_m = 1'b1;
  endtask

  task automatic check_bank(input string req);
    for (int i = 0; i < NREG; i++)
      chk(req, 32'(cfg_flat[i*8 +: 8]), 32'(model[i]));
  endtask

  task automatic reset_model();
    for (int i = 0; i < NREG; i++) model[i] = dflt(i);
  endtask

  logic       ack;
  logic [7:0] rb;
  logic       st;

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    reset_model();
    wq(5);
    chk("R1 oe in reset", 32'(sda_oe), 0);
    rst_n = 1'b1;
    wq(5);
    chk("R1 oe after reset", 32'(sda_oe), 0);
    check_bank("R1 defaults");

    // basic multi-byte write at pointer 2, address select 0
    bus_start();
    send_byte(8'h30, ack); chk("R2 match ack sel0", 32'(ack), 1);
    send_byte(8'h02, ack); chk("R3 ptr ack", 32'(ack), 1);
    for (int k = 0; k < 3; k++) begin
      send_byte(8'(8'hA0 + k), ack); chk("R5 data ack", 32'(ack), 1);
      model[2+k] = 8'(8'hA0 + k);
    end
    bus_stop();
    wq(4);
    chk("R8 oe after stop", 32'(sda_oe), 0);
    check_bank("R5 multi write");

    // sweep of start pointers through and past the bank
    for (int s = 0; s < NREG + 2; s++) begin
      bus_start();
      send_byte(8'h30, ack); chk("R2 ack", 32'(ack), 1);
      send_byte(8'(s), ack); chk("R3 ack", 32'(ack), 1);
      for (int k = 0; k < 2; k++) begin
        send_byte(8'(s*29 + k*7 + 3), ack); chk("R6 ack any ptr", 32'(ack), 1);
        if (s + k < NREG) model[s+k] = 8'(s*29 + k*7 + 3);
      end
      bus_stop();
      check_bank("R6 write range");
      bus_start();
      send_byte(8'h30, ack);
      send_byte(8'(s), ack);
      bus_start();
      send_byte(8'h31, ack); chk("R7 read addr ack", 32'(ack), 1);
      for (int k = 0; k < 2; k++) begin
        read_byte(k == 0, rb, st);
        chk("R7 read data", 32'(rb), (s + k < NREG) ? 32'(model[s+k]) : 32'h0);
        chk("R4 bit steady", 32'(st), 1);
      end
      wq(2);
      chk("R7 release after nack", 32'(sda_oe), 0);
      bus_stop();
    end

    // pointer wrap from 255 to 0
    bus_start();
    send_byte(8'h30, ack);
    send_byte(8'hFF, ack);
    send_byte(8'h11, ack);
    send_byte(8'h22, ack);
    bus_stop();
    model[0] = 8'h22;
    check_bank("R5 wrap");

    // address select 1: old address ignored, new address accepted
    addr_sel = 1'b1;
    bus_start();
    send_byte(8'h30, ack); chk("R2 mismatch nack", 32'(ack), 0);
    send_byte(8'h01, ack); chk("R2 ignored ptr", 32'(ack), 0);
    send_byte(8'h5A, ack); chk("R2 ignored data", 32'(ack), 0);
    bus_stop();
    check_bank("R2 no change on mismatch");
    bus_start();
    send_byte(8'h32, ack); chk("R2 match ack sel1", 32'(ack), 1);
    send_byte(8'h01, ack);
    send_byte(8'h77, ack);
    bus_stop();
    model[1] = 8'h77;
    check_bank("R2 sel1 write");

    // pointer kept across STOP, read with no pointer byte
    bus_start();
    send_byte(8'h32, ack);
    send_byte(8'h05, ack);
    bus_stop();
    bus_start();
    send_byte(8'h33, ack); chk("R3 read ack", 32'(ack), 1);
    read_byte(1'b0, rb, st);
    chk("R3 pointer kept", 32'(rb), 32'(model[5]));
    bus_stop();

    // START abandons a partial data byte
    bus_start();
    send_byte(8'h32, ack);
    send_byte(8'h06, ack);
    for (int i = 0; i < 4; i++) begin
      sda_m = 1'b0; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0;
    end
    bus_start();
    send_byte(8'h32, ack); chk("R8 restart ack", 32'(ack), 1);
    send_byte(8'h07, ack);
    send_byte(8'h3C, ack);
    bus_stop();
    model[7] = 8'h3C;
    check_bank("R8 partial byte dropped");

    // reset in mid transfer
    bus_start();
    send_byte(8'h32, ack);
    send_byte(8'h08, ack);
    for (int i = 0; i < 3; i++) begin
      sda_m = 1'b1; wq(Q);
      scl_m = 1'b1; wq(2*Q);
      scl_m = 1'b0;
    end
    rst_n = 1'b0; wq(4);
    rst_n = 1'b1; wq(4);
    chk("R9 oe released", 32'(sda_oe), 0);
    reset_model();
    check_bank("R9 defaults");
    sda_m = 1'b1; scl_m = 1'b1; wq(Q);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule